// File: doc/BRIEF.md
# Time-Multiplexed Stereo Channel Mixer

This block combines up to eight mono sample streams into one 16-bit stereo pair per sample period. The channels do not have parallel adders. A single scaling and accumulation datapath is shared in time: at the start of each period the block fetches one sample per active channel, in ascending channel order and one per clock. It scales each sample by that channel's pan setting into a left part and a right part, and sums the parts. When the last slot is done, it saturates the two sums and registers them as the period's output.

A small write-only register port sets the number of active channels (1, 2, 4 or 8), the sample width (16-bit, or 8-bit placed in the upper byte), the period length, and a 3-bit pan code for each channel. The sample source answers each fetch in the same cycle with data and an availability bit. A fetch that finds no sample adds zero and marks that period's result as an underrun.

Top module: `stereo_tdm_mixer`

## Requirements
- R1: After synchronous reset, out_valid, out_left, out_right and out_underrun are 0. The defaults are one active channel, 16-bit samples, a rate value of 0 and every pan code 0. In the first cycle after reset, smp_rd is 1 with smp_ch 0.
- R2: The count code maps 0, 1, 2, 3 to N = 1, 2, 4, 8 active channels. A period starts with N consecutive cycles that have smp_rd high and smp_ch = 0, 1, …, N-1. smp_rd is low in every other cycle of the period.
- R3: With rate value D, a period lasts max(D+1, N+1) cycles. out_valid is high for exactly one cycle per period, two cycles after the period's last fetch cycle.
- R4: Pan code p gives a right weight w equal to p for p < 7 and 8 for p = 7. The left weight is 8 - w. A sample s contributes floor(s*(8-w)/8) to the left sum and floor(s*w/8) to the right sum.
- R5: out_left and out_right are the sums of all of the period's contributions, clamped to the range -32768 to 32767.
- R6: In 8-bit mode, smp_data[7:0] forms the upper byte of the 16-bit sample and the lower byte is zero. smp_data[15:8] is ignored.
- R7: A fetch made with smp_avail low adds a sample of zero. out_underrun is 1 with that period's result, and 0 with a result in which every fetch found data.
- R8: Register map. Address 0 holds the count code in bits [1:0] and selects 8-bit mode with bit 2. Address 1 holds the rate value D. Addresses 8+k hold the pan code of channel k in bits [2:0]. A write to any other address changes no setting.
- R9: Any register write restarts the period in the next cycle at slot 0 and drops any partial sums. The outputs keep their last result until the next out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| smp_rd | output | 1 | Sample fetch strobe for this cycle |
| smp_ch | output | 3 | Channel being fetched |
| smp_avail | input | 1 | Sample source has data for smp_ch |
| smp_data | input | 16 | Sample for smp_ch |
| out_valid | output | 1 | One-cycle pulse: a new stereo result is present |
| out_left | output | 16 | Signed left result |
| out_right | output | 16 | Signed right result |
| out_underrun | output | 1 | Some fetch of the reported period found no data |

## Verification
The assertions check on every cycle that fetches step through consecutive channels, that out_valid never lasts more than one cycle, and that a register write sends the sequencer back to slot 0. They also check that the full-left and full-right pan codes silence the opposite side, that an over-range sum comes out at the clamp value, and that a missed fetch shows up in the next result's underrun flag. Only the bench scenarios can show the exact weighted sums across channel counts, the period length under different rate values, the 8-bit placement with the upper input byte ignored, and that a write to an unused address leaves every setting unchanged.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int ADDR_MODE = 0;
  localparam int ADDR_RATE = 1;
  localparam int ADDR_POS_BASE = 8;
  localparam int POS_W = 3;

  // right-side weight in eighths for a pan code; left side is 8 minus this
  function automatic logic [3:0] right_weight(input logic [POS_W-1:0] p);
    return (p == 3'd7) ? 4'd8 : {1'b0, p};
  endfunction
endpackage

// File: rtl/mix_cfg_regs.sv
module mix_cfg_regs #(
  parameter int CH_MAX = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int CODE_W = $clog2($clog2(CH_MAX) + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [CODE_W-1:0]           cnt_code,
  output logic                        mode8,
  output logic [DATA_W-1:0]           rate,
  output logic [CH_MAX*mix_pkg::POS_W-1:0] pos_flat
);
  import mix_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_code <= '0;
      mode8    <= 1'b0;
      rate     <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(ADDR_MODE)) begin
        cnt_code <= wdata[CODE_W-1:0];
        mode8    <= wdata[CODE_W];
      end
      if (addr == ADDR_W'(ADDR_RATE))
        rate <= wdata;
    end
  end

  for (genvar k = 0; k < CH_MAX; k++) begin : g_pos
    logic [POS_W-1:0] pos_q;
    always_ff @(posedge clk) begin
      if (rst)
        pos_q <= '0;
      else if (we && addr == ADDR_W'(ADDR_POS_BASE + k))
        pos_q <= wdata[POS_W-1:0];
    end
    assign pos_flat[k*POS_W +: POS_W] = pos_q;
  end
endmodule

// File: rtl/mix_slot_seq.sv
module mix_slot_seq #(
  parameter int CH_MAX = 8,
  parameter int RATE_W = 8,
  localparam int CH_LG  = $clog2(CH_MAX),
  localparam int CODE_W = $clog2(CH_LG + 1),
  localparam int CW     = ((RATE_W > CH_LG + 1) ? RATE_W : CH_LG + 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [CODE_W-1:0] cnt_code,
  input  logic [RATE_W-1:0] rate,
  output logic              fetch,
  output logic [CH_LG-1:0]  fetch_ch,
  output logic              first,
  output logic              latch
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] nact;
  logic [CW-1:0] last;

  always_comb begin
    nact = CW'(1) << cnt_code;
    last = (CW'(rate) > nact) ? CW'(rate) : nact;
  end

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt <= '0;
    else if (cnt >= last)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  assign fetch    = cnt < nact;
  assign fetch_ch = cnt[CH_LG-1:0];
  assign first    = cnt == '0;
  assign latch    = cnt == nact;

  // R2: fetches inside one period walk through consecutive channels
  a_r2_slot_order: assert property (@(posedge clk) disable iff (rst)
    (fetch && !restart && cnt + 1'b1 < nact) |=>
      (fetch && fetch_ch == CH_LG'($past(fetch_ch) + 1'b1)));

  // R9: a register write sends the sequencer back to slot 0
  a_r9_restart_slot0: assert property (@(posedge clk) disable iff (rst)
    restart |=> (first && fetch && fetch_ch == '0));
endmodule

// File: rtl/mix_pan_scale.sv
module mix_pan_scale #(
  parameter int SMP_W = 16
) (
  input  logic                        avail,
  input  logic                        mode8,
  input  logic [SMP_W-1:0]            raw,
  input  logic [mix_pkg::POS_W-1:0]   pos,
  output logic signed [SMP_W-1:0]     part_l,
  output logic signed [SMP_W-1:0]     part_r,
  output logic                        miss
);
  import mix_pkg::*;
  localparam int HALF = SMP_W / 2;
  localparam int PW = SMP_W + 5;

  logic signed [SMP_W-1:0] smp;
  logic [3:0] wr, wl;
  logic signed [PW-1:0] sx, pl, pr, sl, sr;

  always_comb begin
    miss = !avail;
    if (!avail)
      smp = '0;
    else if (mode8)
      smp = {raw[HALF-1:0], {HALF{1'b0}}};
    else
      smp = raw;
    wr = right_weight(pos);
    wl = 4'd8 - wr;
    sx = {{5{smp[SMP_W-1]}}, smp};
    pl = sx * $signed({{(PW-4){1'b0}}, wl});
    pr = sx * $signed({{(PW-4){1'b0}}, wr});
    sl = pl >>> 3;
    sr = pr >>> 3;
    part_l = sl[SMP_W-1:0];
    part_r = sr[SMP_W-1:0];
  end
endmodule

// File: rtl/mix_accum.sv
module mix_accum #(
  parameter int SMP_W = 16,
  parameter int CH_MAX = 8,
  localparam int ACC_W = SMP_W + $clog2(CH_MAX) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    restart,
  input  logic                    fetch,
  input  logic                    first,
  input  logic                    latch,
  input  logic signed [SMP_W-1:0] part_l,
  input  logic signed [SMP_W-1:0] part_r,
  input  logic                    miss,
  output logic                    out_valid,
  output logic [SMP_W-1:0]        out_l,
  output logic [SMP_W-1:0]        out_r,
  output logic                    out_ur
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (SMP_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  logic signed [ACC_W-1:0] acc_l, acc_r;
  logic                    ur_pend;

  function automatic logic [SMP_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
    if (v > SAT_HI) return SAT_HI[SMP_W-1:0];
    if (v < SAT_LO) return SAT_LO[SMP_W-1:0];
    return v[SMP_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_l     <= '0;
      acc_r     <= '0;
      ur_pend   <= 1'b0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
      out_ur    <= 1'b0;
    end else begin
      out_valid <= latch && !restart;
      if (fetch && !restart) begin
        acc_l   <= (first ? '0 : acc_l) + {{(ACC_W-SMP_W){part_l[SMP_W-1]}}, part_l};
        acc_r   <= (first ? '0 : acc_r) + {{(ACC_W-SMP_W){part_r[SMP_W-1]}}, part_r};
        ur_pend <= (first ? 1'b0 : ur_pend) | miss;
      end
      if (latch && !restart) begin
        out_l  <= clamp(acc_l);
        out_r  <= clamp(acc_r);
        out_ur <= ur_pend;
      end
    end
  end

  // R3: result strobe is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5: an over-range sum is reported at the clamp limit
  a_r5_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (latch && !restart && acc_l > SAT_HI) |=> out_l == SAT_HI[SMP_W-1:0]);

  a_r5_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (latch && !restart && acc_r < SAT_LO) |=> out_r == SAT_LO[SMP_W-1:0]);

  // R7: a missed fetch is remembered and reported with the result
  a_r7_miss_recorded: assert property (@(posedge clk) disable iff (rst)
    (fetch && miss && !restart) |=> ur_pend);

  a_r7_miss_reported: assert property (@(posedge clk) disable iff (rst)
    (latch && ur_pend && !restart) |=> (out_valid && out_ur));
endmodule

// File: rtl/stereo_tdm_mixer.sv
module stereo_tdm_mixer #(
  parameter int CH_MAX = 8,
  parameter int SMP_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int CH_LG  = $clog2(CH_MAX),
  localparam int CODE_W = $clog2(CH_LG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              smp_rd,
  output logic [CH_LG-1:0]  smp_ch,
  input  logic              smp_avail,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              out_valid,
  output logic [SMP_W-1:0]  out_left,
  output logic [SMP_W-1:0]  out_right,
  output logic              out_underrun
);
  import mix_pkg::*;

  logic [CODE_W-1:0]       cnt_code;
  logic                    mode8;
  logic [DATA_W-1:0]       rate;
  logic [CH_MAX*POS_W-1:0] pos_flat;
  logic [POS_W-1:0]        pos_sel;
  logic                    fetch, first, latch, miss;
  logic signed [SMP_W-1:0] part_l, part_r;

  mix_cfg_regs #(.CH_MAX(CH_MAX), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cnt_code(cnt_code), .mode8(mode8), .rate(rate), .pos_flat(pos_flat)
  );

  mix_slot_seq #(.CH_MAX(CH_MAX), .RATE_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .restart(cfg_we), .cnt_code(cnt_code), .rate(rate),
    .fetch(fetch), .fetch_ch(smp_ch), .first(first), .latch(latch)
  );

  assign smp_rd  = fetch;
  assign pos_sel = pos_flat[smp_ch*POS_W +: POS_W];

  mix_pan_scale #(.SMP_W(SMP_W)) u_pan (
    .avail(smp_avail), .mode8(mode8), .raw(smp_data), .pos(pos_sel),
    .part_l(part_l), .part_r(part_r), .miss(miss)
  );

  mix_accum #(.SMP_W(SMP_W), .CH_MAX(CH_MAX)) u_acc (
    .clk(clk), .rst(rst), .restart(cfg_we), .fetch(fetch), .first(first),
    .latch(latch), .part_l(part_l), .part_r(part_r), .miss(miss),
    .out_valid(out_valid), .out_l(out_left), .out_r(out_right), .out_ur(out_underrun)
  );

  // R4: the hard-left code puts nothing on the right, the hard-right code nothing on the left
  a_r4_hard_left: assert property (@(posedge clk) disable iff (rst)
    (fetch && pos_sel == 3'd0) |-> part_r == '0);

  a_r4_hard_right: assert property (@(posedge clk) disable iff (rst)
    (fetch && pos_sel == 3'd7) |-> part_l == '0);
endmodule

// File: tb/tb_stereo_tdm_mixer.sv
module tb_stereo_tdm_mixer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        smp_rd;
  logic [2:0]  smp_ch;
  logic        smp_avail;
  logic [15:0] smp_data;
  logic        out_valid;
  logic [15:0] out_left, out_right;
  logic        out_underrun;

  logic [15:0] sval [8];
  logic [7:0]  miss_mask = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  stereo_tdm_mixer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .smp_rd(smp_rd), .smp_ch(smp_ch), .smp_avail(smp_avail), .smp_data(smp_data),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .out_underrun(out_underrun)
  );

  always_comb begin
    smp_data  = sval[smp_ch];
    smp_avail = !miss_mask[smp_ch];
  end

  // ---------------- behavioural reference ----------------
  int m_code, m_8, m_rate, m_cnt, m_al, m_ar, m_ur;
  int m_pos [8];
  int e_valid, e_l, e_r, e_ur;

  function automatic int rweight(int p);
    return (p == 7) ? 8 : p;
  endfunction

  function automatic int clamp16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_code = 0; m_8 = 0; m_rate = 0; m_cnt = 0;
      m_al = 0; m_ar = 0; m_ur = 0;
      for (int k = 0; k < 8; k++) m_pos[k] = 0;
      e_valid = 0; e_l = 0; e_r = 0; e_ur = 0;
    end else if (cfg_we) begin
      if (cfg_addr == 4'd0) begin m_code = cfg_wdata[1:0]; m_8 = cfg_wdata[2]; end
      if (cfg_addr == 4'd1) m_rate = cfg_wdata;
      if (cfg_addr >= 4'd8) m_pos[cfg_addr - 8] = cfg_wdata[2:0];
      m_cnt = 0;
      e_valid = 0;
    end else begin
      int n, s, w, lastc;
      n = 1 << m_code;
      if (m_cnt < n) begin
        if (m_cnt == 0) begin m_al = 0; m_ar = 0; m_ur = 0; end
        if (miss_mask[m_cnt]) begin
          s = 0; m_ur = 1;
        end else if (m_8 != 0) begin
          s = $signed({sval[m_cnt][7:0], 8'h00});
        end else begin
          s = $signed(sval[m_cnt]);
        end
        w = rweight(m_pos[m_cnt]);
        m_al += (s * (8 - w)) >>> 3;
        m_ar += (s * w) >>> 3;
      end
      e_valid = (m_cnt == n);
      if (e_valid) begin e_l = clamp16(m_al); e_r = clamp16(m_ar); e_ur = m_ur; end
      lastc = (m_rate > n) ? m_rate : n;
      m_cnt = (m_cnt >= lastc) ? 0 : m_cnt + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int n;
      n = 1 << m_code;
      check("R2 fetch strobe", smp_rd, (m_cnt < n) ? 1 : 0);
      if (m_cnt < n) check("R2 fetch channel", smp_ch, m_cnt);
      check("R3 result strobe", out_valid, e_valid);
      check("R4 R9 left", $signed(out_left), e_l);
      check("R4 R9 right", $signed(out_right), e_r);
      check("R7 underrun", out_underrun, e_ur);
    end
  end

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_result();
    int t = 0;
    @(negedge clk);
    while (!out_valid && t < 600) begin @(negedge clk); t++; end
  endtask

  int gap;

  initial begin
    for (int k = 0; k < 8; k++) sval[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    check("R1 valid", out_valid, 0);
    check("R1 left", out_left, 0);
    check("R1 right", out_right, 0);
    check("R1 underrun", out_underrun, 0);
    check("R1 fetch", smp_rd, 1);
    check("R1 channel", smp_ch, 0);

    // R4: one channel, hard left
    sval[0] = 16'd1000;
    wait_result(); wait_result();
    check("R4 single left", $signed(out_left), 1000);
    check("R4 single right", $signed(out_right), 0);

    // R2 R3: two channels, rate 5 gives 6-cycle period
    cfg_write(0, 1); cfg_write(1, 5);
    cfg_write(8, 7); cfg_write(9, 3);
    sval[0] = 16'd800; sval[1] = -16'sd800;
    wait_result(); wait_result();
    check("R4 two-channel left", $signed(out_left), -500);
    check("R4 two-channel right", $signed(out_right), 500);
    gap = 0;
    @(negedge clk);
    while (!out_valid && gap < 50) begin gap++; @(negedge clk); end
    check("R3 period length", gap + 1, 6);

    // R3: four channels, rate 0 gives N+1 cycles
    cfg_write(1, 0); cfg_write(0, 2);
    cfg_write(10, 1); cfg_write(11, 6);
    sval[2] = 16'd4000; sval[3] = 16'd123;
    wait_result();
    gap = 0;
    @(negedge clk);
    while (!out_valid && gap < 50) begin gap++; @(negedge clk); end
    check("R3 short period", gap + 1, 5);

    // R5: eight channels saturate high on left, low on right
    cfg_write(0, 3);
    for (int k = 0; k < 8; k++) begin sval[k] = 16'd30000; cfg_write(8 + k, 0); end
    wait_result(); wait_result();
    check("R5 clamp high", $signed(out_left), 32767);
    for (int k = 0; k < 8; k++) begin sval[k] = -16'sd30000; cfg_write(8 + k, 7); end
    wait_result(); wait_result();
    check("R5 clamp low", $signed(out_right), -32768);
    check("R5 other side", $signed(out_left), 0);

    // R6: 8-bit mode, upper input byte ignored
    cfg_write(8, 0); cfg_write(0, 4);
    sval[0] = 16'hAB80;
    wait_result(); wait_result();
    check("R6 byte placement", $signed(out_left), -32768);
    sval[0] = 16'h1234;
    wait_result(); wait_result();
    check("R6 upper byte ignored", $signed(out_left), 13312);

    // R7: four channels, channel 2 missing
    cfg_write(0, 2);
    for (int k = 0; k < 4; k++) begin sval[k] = 16'd100; cfg_write(8 + k, 0); end
    miss_mask = 8'b0000_0100;
    wait_result(); wait_result();
    check("R7 missing counts zero", $signed(out_left), 300);
    check("R7 flag set", out_underrun, 1);
    miss_mask = '0;
    wait_result(); wait_result();
    check("R7 flag clears", out_underrun, 0);

    // R8: write to an unused address changes nothing
    cfg_write(5, 8'hFF);
    wait_result();
    check("R8 unused address", $signed(out_left), 400);
    wait_result();
    check("R8 unused address again", $signed(out_left), 400);

    // R9: restart in the middle of a period holds the old result
    cfg_write(1, 20);
    repeat (3) @(negedge clk);
    cfg_write(8, 0);
    check("R9 held through restart", $signed(out_left), 400);
    wait_result();
    check("R9 result after restart", $signed(out_left), 400);

    repeat (30) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule